// File: doc/BRIEF.md
# Instruction Cache ECC Fault Injection Controller

This block sits beside an instruction cache. It holds a control/status register and a target-address register behind a simple register read/write port. Software uses the control register to switch ECC checking on and to start a one-shot fault injection into either the metadata array or the data array. The target-address register names the physical address whose line is to be corrupted.

When an injection is started, the controller checks the request first. If the request is valid, it sends the cache a request carrying the target array and the address, using a valid/ready handshake. It then waits for one of two answers from the cache: a miss, which means the address is not cached, or a completion pulse, which means the array write has finished. A read-only status field tracks the progress of the injection. A separate reason code says why an injection failed. Software polls the control register, and the read that returns a final status also returns the status to idle.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, both registers read as zero, `ecc_en_o` is 0 and no request is pending.
- R2: Writing the control register (offset 0x0) updates two fields: bit 0 is the ECC enable and bits 3:2 are the target. Bit 0 is also driven on `ecc_en_o`. When read, bit 1 is 0, bits 6:4 hold the status, bits 9:7 hold the reason, and bits 63:10 are 0.
- R3: The address register (offset 0x8) stores the low PA_W bits of a write. Its bits at PA_W and above read as 0. A read or write at any other offset reads 0 and has no effect.
- R4: A control write with bit 1 set, made while the status is idle (0) and with bit 0 clear, sets the status to error (7) with reason 0. This happens whatever the target, and no request is sent.
- R5: A control write with bit 1 set, made while the status is idle, with bit 0 set and an odd target (reserved codes 1 or 3), sets the status to error with reason 1. No request is sent.
- R6: A control write with bit 1 set, made while the status is idle, with bit 0 set and target 0 (metadata) or 2 (data), sets the status to working (1) from the next cycle. `inj_req_valid_o` is then raised, carrying that target and the stored address. Valid, target and address stay unchanged until `inj_req_ready_i` is seen high.
- R7: After the request is accepted, `inj_miss_i` sets the status to error with reason 2, and `inj_done_i` sets the status to injected (2). If both arrive in the same cycle, the miss wins.
- R8: A control read while the status is injected or error returns that status, and the status is idle from the next cycle. A control read while the status is idle or working leaves the status unchanged.
- R9: A control write with bit 1 set, made while the status is working, starts nothing and leaves the request unchanged. The enable and target fields still take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data (combinational, valid while reg_rd_i is high) |
| ecc_en_o | output | 1 | ECC check enable to the cache |
| inj_req_valid_o | output | 1 | Injection request valid |
| inj_req_ready_i | input | 1 | Injection request accepted |
| inj_req_target_o | output | 2 | Target array code of the request |
| inj_req_addr_o | output | PA_W | Physical address of the request |
| inj_miss_i | input | 1 | Cache reports that the address is not present |
| inj_done_i | input | 1 | Cache reports that the array write is complete |

## Verification
The assertions check, on every cycle, the following:
- A pending request keeps its target and address until it is accepted.
- The status never shows a reserved code.
- A final status clears on a control read.
- An inject write with checking disabled goes straight to error.

Only the bench scenarios can show the rest:
- The order in which the checks are made.
- The reason code seen for each combination of enable and target.
- That an inject write made while working leaves the request alone but still updates the fields.
- The address truncation as it reads back through the register port.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WORK = 3'd1,
    ST_DONE = 3'd2,
    ST_ERR  = 3'd7
  } inj_status_e;

  localparam logic [2:0] RSN_OFF  = 3'd0;
  localparam logic [2:0] RSN_TGT  = 3'd1;
  localparam logic [2:0] RSN_MISS = 3'd2;

  localparam logic [1:0] TGT_META = 2'd0;
  localparam logic [1:0] TGT_DATA = 2'd2;

  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned ADDR_OFS = 8;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs #(
  parameter int unsigned PA_W = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_wr_i,
  input  logic            addr_wr_i,
  input  logic [63:0]     wdata_i,
  output logic            en_o,
  output logic [1:0]      tgt_o,
  output logic [PA_W-1:0] paddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      tgt_o   <= 2'd0;
      paddr_o <= '0;
    end else begin
      if (ctrl_wr_i) begin
        en_o  <= wdata_i[0];
        tgt_o <= wdata_i[3:2];
      end
      if (addr_wr_i) paddr_o <= wdata_i[PA_W-1:0];
    end
  end
endmodule

// File: rtl/ecc_inj_fsm.sv
module ecc_inj_fsm
  import ecc_inj_pkg::*;
#(
  parameter int unsigned PA_W = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inject_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_tgt_i,
  input  logic [PA_W-1:0] paddr_i,
  input  logic            ctrl_rd_i,
  input  logic            req_ready_i,
  input  logic            miss_i,
  input  logic            done_i,
  output logic [2:0]      status_o,
  output logic [2:0]      reason_o,
  output logic            req_valid_o,
  output logic [1:0]      req_target_o,
  output logic [PA_W-1:0] req_addr_o
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_DONE, S_ERR} state_e;
  state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      reason_o     <= RSN_OFF;
      req_target_o <= TGT_META;
      req_addr_o   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (inject_i) begin
          if (!wr_en_i) begin
            state_q  <= S_ERR;
            reason_o <= RSN_OFF;
          end else if (wr_tgt_i[0]) begin
            state_q  <= S_ERR;
            reason_o <= RSN_TGT;
          end else begin
            state_q      <= S_REQ;
            req_target_o <= wr_tgt_i;
            req_addr_o   <= paddr_i;
          end
        end
        S_REQ:  if (req_ready_i) state_q <= S_WAIT;
        S_WAIT: begin
          if (miss_i) begin
            state_q  <= S_ERR;
            reason_o <= RSN_MISS;
          end else if (done_i) begin
            state_q <= S_DONE;
          end
        end
        S_DONE, S_ERR: if (ctrl_rd_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == S_REQ);

  always_comb begin
    unique case (state_q)
      S_REQ, S_WAIT: status_o = ST_WORK;
      S_DONE:        status_o = ST_DONE;
      S_ERR:         status_o = ST_ERR;
      default:       status_o = ST_IDLE;
    endcase
  end

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_target_o) && $stable(req_addr_o)));

  // R4
  off_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && inject_i && !wr_en_i) |=>
      (status_o == ST_ERR && reason_o == RSN_OFF && !req_valid_o));

  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i && (status_o == ST_DONE || status_o == ST_ERR)) |=>
      (status_o == ST_IDLE));

  // R9
  busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_WORK && inject_i) |=> (status_o != ST_IDLE));
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PA_W   = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              ecc_en_o,
  output logic              inj_req_valid_o,
  input  logic              inj_req_ready_i,
  output logic [1:0]        inj_req_target_o,
  output logic [PA_W-1:0]   inj_req_addr_o,
  input  logic              inj_miss_i,
  input  logic              inj_done_i
);
  logic sel_ctrl, sel_addr;
  logic ctrl_wr, addr_wr, ctrl_rd, inject;
  logic [1:0] tgt;
  logic [PA_W-1:0] paddr;
  logic [2:0] status, reason;
  logic unused_w;

  assign sel_ctrl = (reg_addr_i == ADDR_W'(CTRL_OFS));
  assign sel_addr = (reg_addr_i == ADDR_W'(ADDR_OFS));
  assign ctrl_wr  = reg_wr_i && sel_ctrl;
  assign addr_wr  = reg_wr_i && sel_addr;
  assign ctrl_rd  = reg_rd_i && sel_ctrl;
  assign inject   = ctrl_wr && reg_wdata_i[1];
  assign unused_w = ^reg_wdata_i;

  ecc_inj_regs #(.PA_W(PA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .addr_wr_i (addr_wr),
    .wdata_i   (reg_wdata_i),
    .en_o      (ecc_en_o),
    .tgt_o     (tgt),
    .paddr_o   (paddr)
  );

  ecc_inj_fsm #(.PA_W(PA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inject_i     (inject),
    .wr_en_i      (reg_wdata_i[0]),
    .wr_tgt_i     (reg_wdata_i[3:2]),
    .paddr_i      (paddr),
    .ctrl_rd_i    (ctrl_rd),
    .req_ready_i  (inj_req_ready_i),
    .miss_i       (inj_miss_i),
    .done_i       (inj_done_i),
    .status_o     (status),
    .reason_o     (reason),
    .req_valid_o  (inj_req_valid_o),
    .req_target_o (inj_req_target_o),
    .req_addr_o   (inj_req_addr_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (sel_ctrl) begin
        reg_rdata_o[0]   = ecc_en_o;
        reg_rdata_o[3:2] = tgt;
        reg_rdata_o[6:4] = status;
        reg_rdata_o[9:7] = reason;
      end else if (sel_addr) begin
        reg_rdata_o[PA_W-1:0] = paddr;
      end
    end
  end

  // R2
  status_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == ST_IDLE || status == ST_WORK || status == ST_DONE || status == ST_ERR));

  // R6
  valid_work_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_req_valid_o |-> (status == ST_WORK && !inj_req_target_o[0]));
endmodule

// File: tb/tb_ecc_inject_ctrl.sv
module tb_ecc_inject_ctrl;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PA_W   = 48;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0, reg_rdata_o;
  logic ecc_en_o, inj_req_valid_o, inj_req_ready_i = 0;
  logic [1:0] inj_req_target_o;
  logic [PA_W-1:0] inj_req_addr_o;
  logic inj_miss_i = 0, inj_done_i = 0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ecc_inject_ctrl #(.ADDR_W(ADDR_W), .PA_W(PA_W)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk_i);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    @(negedge clk_i);
    reg_rd_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  function automatic logic [63:0] ctrl_val(bit en, logic [1:0] t, logic [2:0] st, logic [2:0] rs);
    logic [63:0] v = '0;
    v[0] = en; v[3:2] = t; v[6:4] = st; v[9:7] = rs;
    return v;
  endfunction

  function automatic logic [63:0] cmd(bit en, bit inj, logic [1:0] t);
    return {54'h3F_FFFF_FFFF_FFFF, 6'd0, t, inj, en} & 64'hFFFF_FFFF_FFFF_FC0F;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] d;
    logic [PA_W-1:0] pa;
    #20 rst_ni = 1;

    // R1 reset state
    rd(4'h0, d); chk("R1 ctrl", d, 64'd0);
    rd(4'h8, d); chk("R1 addr", d, 64'd0);
    chk("R1 valid", {63'd0, inj_req_valid_o}, 64'd0);
    chk("R1 en", {63'd0, ecc_en_o}, 64'd0);

    // R3 address truncation and unmapped offset
    wr(4'h8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'h8, d); chk("R3 trunc", d, 64'h0000_FFFF_FFFF_FFFF);
    wr(4'h4, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'h4, d); chk("R3 other ofs", d, 64'd0);
    rd(4'h0, d); chk("R3 ctrl untouched", d, 64'd0);

    // R2 fields without inject, upper bits ignored
    wr(4'h0, 64'hFFFF_FFFF_FFFF_FC0D);
    rd(4'h0, d); chk("R2 fields", d, ctrl_val(1, 2'd3, 3'd0, 3'd0));
    chk("R2 ecc_en_o", {63'd0, ecc_en_o}, 64'd1);

    // sweep enable x target x response x ready delay
    for (int en = 0; en < 2; en++)
      for (int t = 0; t < 4; t++)
        for (int r = 0; r < 3; r++) begin
          pa = PA_W'(48'h1234_5600_0000) + PA_W'((en * 12 + t * 3 + r) << 6);
          wr(4'h8, 64'(pa));
          wr(4'h0, cmd(en[0], 1, t[1:0]));
          if (!en[0]) begin
            chk("R4 no req", {63'd0, inj_req_valid_o}, 64'd0);
            rd(4'h0, d); chk("R4 err rsn0", d, ctrl_val(0, t[1:0], 3'd7, 3'd0));
          end else if (t[0]) begin
            chk("R5 no req", {63'd0, inj_req_valid_o}, 64'd0);
            rd(4'h0, d); chk("R5 err rsn1", d, ctrl_val(1, t[1:0], 3'd7, 3'd1));
          end else begin
            chk("R6 valid", {63'd0, inj_req_valid_o}, 64'd1);
            chk("R6 target", 64'(inj_req_target_o), 64'(t));
            chk("R6 addr", 64'(inj_req_addr_o), 64'(pa));
            for (int k = 0; k < r; k++) begin
              @(negedge clk_i);
              chk("R6 hold", {63'd0, inj_req_valid_o}, 64'd1);
            end
            // R8 read in working leaves state
            rd(4'h0, d); chk("R8 work read", d, ctrl_val(1, t[1:0], 3'd1, 3'(d[9:7])));
            @(negedge clk_i); inj_req_ready_i = 1;
            @(negedge clk_i); inj_req_ready_i = 0;
            chk("R6 accepted", {63'd0, inj_req_valid_o}, 64'd0);
            @(negedge clk_i);
            inj_miss_i = (r != 0);
            inj_done_i = (r != 1);
            @(negedge clk_i); inj_miss_i = 0; inj_done_i = 0;
            rd(4'h0, d);
            if (r != 0) chk("R7 miss", d, ctrl_val(1, t[1:0], 3'd7, 3'd2));
            else        chk("R7 done", d[6:0], ctrl_val(1, t[1:0], 3'd2, 3'd0) & 64'h7F);
          end
          rd(4'h0, d); chk("R8 cleared", 64'(d[6:4]), 64'd0);
        end

    // R9 inject while working
    wr(4'h8, 64'h0000_0000_ABCD_0040);
    wr(4'h0, cmd(1, 1, 2'd2));
    wr(4'h0, cmd(1, 1, 2'd0));
    chk("R9 still valid", {63'd0, inj_req_valid_o}, 64'd1);
    chk("R9 target kept", 64'(inj_req_target_o), 64'd2);
    chk("R9 addr kept", 64'(inj_req_addr_o), 64'hABCD_0040);
    rd(4'h0, d); chk("R9 fields updated", d[6:0], ctrl_val(1, 2'd0, 3'd1, 3'd0) & 64'h7F);
    wr(4'h0, cmd(0, 1, 2'd2));
    chk("R9 en off still busy", {63'd0, inj_req_valid_o}, 64'd1);
    chk("R9 ecc_en_o", {63'd0, ecc_en_o}, 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule